// File: doc/BRIEF.md
# Random byte assembler with hold

This block builds bytes out of random bits that arrive one at a time, each marked by a one-cycle valid strobe. Each accepted bit goes into the next free position of a small bit store. When the final position is filled, the whole byte is copied at once into an output register. Downstream logic therefore only ever sees complete bytes, never a byte that is still being built. The bit source drops the bits it cannot decide, so those bits never arrive here. Bytes simply take longer to complete when many bits are dropped.

A hold level lets the user freeze the published byte, for example while reading a display. Bit collection carries on while the hold is in force. If a byte completes during the hold, it waits in a pending register. If a later byte completes before the hold ends, the later byte replaces the waiting one. The waiting byte is published as soon as the synchronized hold drops. A one-cycle ready pulse marks every update of the output. A display-enable level tells the display path that a real byte has been shown since reset.

Top module: `rand_byte_gather`

## Requirements
- R1: The first accepted bit after reset, or after a byte completes, lands in bit 0 of the byte (the LSB). Each following accepted bit goes to the next higher bit position, and the byte completes with bit 7.
- R2: `word_out` changes only when a complete byte is published. While a byte is partly assembled, the previously published value stays on the output.
- R3: The clock edge that samples the eighth valid strobe, with hold inactive, loads `word_out` with that bit in position 7 together with the seven stored bits.
- R4: `bit_in` is ignored on any cycle in which `bit_vld` is low. Such a cycle neither stores a bit nor advances the position.
- R5: While the synchronized hold is high, `word_out` keeps its value and no ready pulse is raised, but bits are still collected.
- R6: A byte completed during the hold is published on the first edge at which the synchronized hold is low. If several bytes complete during one hold, only the last of them is published.
- R7: `word_ready` is high for exactly the cycle that follows each output update, and `word_out` never changes without it.
- R8: `hold_req` passes through two flops before use. A change on it first affects publishing at the third rising edge after it is driven.
- R9: `disp_en` is low after reset. It goes high with the first publish and stays high until the next reset.
- R10: Synchronous reset clears the bit store, the position counter, the pending byte and the hold synchronizer, and drives `word_out`, `word_ready` and `disp_en` to 0. A byte in progress is abandoned, and the next byte starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe: `bit_in` holds an accepted random bit this cycle |
| bit_in | input | 1 | Random bit |
| hold_req | input | 1 | Asynchronous hold level; freezes the published byte |
| word_out | output | 8 | Last published byte |
| word_ready | output | 1 | One-cycle pulse after each publish |
| disp_en | output | 1 | High once any byte has been published since reset |

## Verification
A position counter that is off by one does not stay hidden. It shifts every bit of the next published byte, and it also moves the publish itself by one strobe. Both effects show up at the first publish after the fault. A stale pending flag would show a spurious ready pulse, or an old byte, on the cycle after the synchronized hold falls. A synchronizer of the wrong depth moves that release by one edge, and the bench checks every cycle against a reference model, so the shift is caught. Lost hold behaviour shows as an output change while hold is held.

// File: rtl/rand_byte_gather.sv
`timescale 1ns/1ps
module rand_byte_gather #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              hold_req,
  output logic [WORD_W-1:0] word_out,
  output logic              word_ready,
  output logic              disp_en
);
  localparam int SEL_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [SEL_W-1:0] LAST_POS = SEL_W'(WORD_W - 1);

  logic [WORD_W-1:0] slots, pend;
  logic [SEL_W-1:0]  sel;
  logic              pend_vld;
  logic              hold_s1, hold_s2;

  wire               last      = bit_vld && (sel == LAST_POS);
  wire [WORD_W-1:0]  done_word = {bit_in, slots[WORD_W-2:0]};
  wire               pub_new   = last && !hold_s2;
  wire               pub_old   = pend_vld && !hold_s2 && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots      <= '0;
      pend       <= '0;
      sel        <= '0;
      pend_vld   <= 1'b0;
      hold_s1    <= 1'b0;
      hold_s2    <= 1'b0;
      word_out   <= '0;
      word_ready <= 1'b0;
      disp_en    <= 1'b0;
    end else begin
      hold_s1    <= hold_req;
      hold_s2    <= hold_s1;
      word_ready <= pub_new || pub_old;
      if (bit_vld) begin
        slots[sel] <= bit_in;
        sel        <= last ? '0 : sel + 1'b1;
      end
      if (last && hold_s2) begin
        pend     <= done_word;
        pend_vld <= 1'b1;
      end
      if (pub_new) begin
        word_out <= done_word;
        pend_vld <= 1'b0;
      end else if (pub_old) begin
        word_out <= pend;
        pend_vld <= 1'b0;
      end
      if (pub_new || pub_old) disp_en <= 1'b1;
    end
  end
endmodule

// File: rtl/rand_byte_gather_chk.sv
`timescale 1ns/1ps
module rand_byte_gather_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hold_req,
  input logic              hold_eff,
  input logic [WORD_W-1:0] word_out,
  input logic              word_ready,
  input logic              disp_en
);
  // R7
  out_change_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(word_out)) |-> word_ready);

  // R9
  disp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    disp_en |=> disp_en);

  // R9
  disp_after_pub_chk: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> disp_en);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (word_out == '0 && !word_ready && !disp_en));

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(hold_eff)) |-> ($stable(word_out) && !word_ready));

  // R8
  hold_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (hold_eff == $past(hold_req, 2)));
endmodule

bind rand_byte_gather rand_byte_gather_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .hold_req(hold_req), .hold_eff(hold_s2),
  .word_out(word_out), .word_ready(word_ready), .disp_en(disp_en)
);

// File: tb/rand_byte_gather_test.sv
`timescale 1ns/1ps
module rand_byte_gather_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0, bit_in = 1'b0, hold_req = 1'b0;
  logic [7:0] word_out;
  logic       word_ready, disp_en;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [7:0] m_slots = '0, m_pend = '0, m_word = '0;
  int         m_sel = 0;
  logic       m_pv = 1'b0, m_h1 = 1'b0, m_h2 = 1'b0, m_rdy = 1'b0, m_den = 1'b0;
  string      word_tag = "R2";

  always #5 clk = ~clk;

  rand_byte_gather uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .hold_req(hold_req),
    .word_out(word_out), .word_ready(word_ready), .disp_en(disp_en)
  );

  function automatic logic [7:0] with_top(input logic [7:0] s, input logic b);
    return {b, s[6:0]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic r, input logic v, input logic b, input logic h);
    logic last, pn, po;
    if (r) begin
      m_slots = '0; m_pend = '0; m_word = '0; m_sel = 0;
      m_pv = 0; m_h1 = 0; m_h2 = 0; m_rdy = 0; m_den = 0;
      return;
    end
    last = v && (m_sel == 7);
    pn = last && !m_h2;
    po = m_pv && !m_h2 && !last;
    m_rdy = pn || po;
    if (last && m_h2) begin m_pend = with_top(m_slots, b); m_pv = 1; end
    if (pn) begin m_word = with_top(m_slots, b); m_pv = 0; end
    else if (po) begin m_word = m_pend; m_pv = 0; end
    if (pn || po) m_den = 1;
    if (v) begin m_slots[m_sel] = b; m_sel = last ? 0 : m_sel + 1; end
    m_h2 = m_h1; m_h1 = h;
  endtask

  task automatic step(input logic r, input logic v, input logic b, input logic h);
    @(negedge clk);
    rst = r; bit_vld = v; bit_in = b; hold_req = h;
    @(posedge clk);
    model_edge(r, v, b, h);
    #1;
    check(word_tag, word_out, m_word);
    check("R7", {7'd0, word_ready}, {7'd0, m_rdy});
    check("R9", {7'd0, disp_en}, {7'd0, m_den});
  endtask

  task automatic send_byte(input logic [7:0] d, input logic h);
    for (int i = 0; i < 8; i++) step(0, 1, d[i], h);
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    // R10 reset state
    word_tag = "R10";
    step(0, 0, 0, 0);
    check("R10", word_out, 8'h00);
    check("R10", {7'd0, disp_en}, 8'h00);

    // R1 R3 ordering, partial words hidden (R2)
    word_tag = "R2";
    for (int i = 0; i < 7; i++) step(0, 1, (i == 0), 0);
    check("R2", word_out, 8'h00);
    step(0, 1, 1, 0);
    check("R1", word_out, 8'h81);
    check("R3", {7'd0, word_ready}, 8'h01);

    // R4 strobe-low bits ignored
    word_tag = "R4";
    for (int i = 0; i < 8; i++) begin
      step(0, 1, (i < 4), 0);
      for (int k = 0; k < 3; k++) step(0, 0, 1'b1, 0);
    end
    check("R4", word_out, 8'h0F);

    // R5 R6 R8 hold
    word_tag = "R5";
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    send_byte(8'hA5, 1);
    check("R5", word_out, 8'h0F);
    check("R5", {7'd0, word_ready}, 8'h00);
    send_byte(8'h3C, 1);
    check("R5", word_out, 8'h0F);
    word_tag = "R8";
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check("R8", word_out, 8'h0F);
    step(0, 0, 0, 0);
    check("R6", word_out, 8'h3C);
    check("R6", {7'd0, word_ready}, 8'h01);
    step(0, 0, 0, 0);
    check("R7", {7'd0, word_ready}, 8'h00);

    // R10 mid-word reset
    word_tag = "R10";
    step(0, 1, 1, 0); step(0, 1, 1, 0); step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    check("R10", word_out, 8'h00);
    check("R10", {7'd0, disp_en}, 8'h00);
    send_byte(8'h55, 0);
    check("R10", word_out, 8'h55);

    // random traffic
    word_tag = "R2";
    begin
      logic h = 0;
      for (int c = 0; c < 4000; c++) begin
        if ($urandom_range(99) < 3) h = ~h;
        step(($urandom_range(199) == 0), ($urandom_range(99) < 40), $urandom_range(1), h);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule